// File: doc/BRIEF.md
# DDR2 Refresh and Power-State Timer

This block tracks when a DDR2 device must be refreshed. It also tracks how long the command path must wait after a refresh or after leaving a low-power state. A down counter sized from the clock period raises a refresh request once per average refresh interval. It uses the shorter interval while the device is hot. Intervals the controller has not served yet are kept as a saturating owed count.

The controller signals each AUTO-REFRESH it issues through the acknowledge input. It also reports entry to and exit from self-refresh and power-down through one-cycle strobes. The block answers with two ready flags. One permits commands other than READ; the other permits READ. Both stay low while the device is in a low-power state and for the recovery time after each event. Recovery limits given in nanoseconds are converted to clock counts at elaboration, rounding up. The block also enforces the minimum time the clock-enable level must be held: a mode-change strobe that comes too soon after the previous mode change is ignored.

Top module: `ddr2_rfsh_timer`

## Requirements
- R1: After reset, ref_req_o is 0, ref_owed_o is 0, both ready flags are 1, and the block is in the running state.
- R2: The first refresh request appears 1560 clock edges after reset is released (7.8 µs at a 5 ns clock). Every interval reload uses 780 edges when hot_i is 1 and 1560 when it is 0. hot_i is sampled at the edge where the reload happens.
- R3: Each interval expiry adds one to ref_owed_o, which saturates at 8. ref_req_o is 1 exactly while ref_owed_o is nonzero. An acknowledge in the running state subtracts one (when nonzero) and reloads the interval counter.
- R4: An acknowledge in the running state holds both ready flags low until 26 edges after the acknowledge edge (127.5 ns rounded up).
- R5: An accepted self-refresh exit raises ready_nr_o 28 edges after the exit edge (tRFC + 10 ns), and ready_rd_o 200 edges after it.
- R6: Accepting a self-refresh entry clears ref_owed_o. No interval expires during self-refresh, and the interval counter reloads on the exit edge.
- R7: When pd_active_i was 0 at power-down entry (precharge power-down), an accepted exit raises both ready flags 2 edges after the exit edge.
- R8: When pd_active_i was 1 at entry (active power-down), ready_nr_o rises 2 edges after exit. With slow_exit_i = 0, ready_rd_o also rises after 2 edges. With slow_exit_i = 1, ready_rd_o rises after max(8 − al_i, 2) edges; slow_exit_i and al_i are sampled on the exit edge.
- R9: A mode change (entry or exit strobe) is accepted only if at least 3 edges have passed since the previous accepted change. An earlier strobe is ignored. If both entry strobes arrive together, self-refresh wins.
- R10: While the block is in self-refresh or power-down, both ready flags are 0 and ref_ack_i is ignored. During power-down, intervals keep expiring and add to ref_owed_o.
- R11: ready_rd_o is never 1 while ready_nr_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hot_i | input | 1 | Case temperature above 85 °C |
| ref_ack_i | input | 1 | AUTO-REFRESH issued this cycle |
| sr_enter_i | input | 1 | Self-refresh entry strobe |
| sr_exit_i | input | 1 | Self-refresh exit strobe |
| pd_enter_i | input | 1 | Power-down entry strobe |
| pd_exit_i | input | 1 | Power-down exit strobe |
| pd_active_i | input | 1 | Power-down entered with a bank open |
| slow_exit_i | input | 1 | Mode-register bit: slow active power-down exit |
| al_i | input | AL_W | Additive latency in clocks |
| ref_req_o | output | 1 | Refresh owed |
| ref_owed_o | output | clog2(OWED_MAX+1) | Count of unserved intervals |
| ready_nr_o | output | 1 | Non-read commands allowed |
| ready_rd_o | output | 1 | READ commands allowed |

## Verification
A wrong interval count or a wrong hot-reload choice moves the edge where ref_owed_o steps up. The model sees this on the first expiry, within one interval. A recovery counter loaded with the wrong value, or one that does not take the larger of old and new waits, makes a ready flag rise early or late, on the exact edge it is due. A mode register that takes a strobe it should refuse shows up on the next cycle: the ready flags drop, or stay low, against the model.

// File: rtl/ddr2_tmr_pkg.sv
package ddr2_tmr_pkg;
  typedef enum logic [1:0] {MODE_RUN, MODE_SREF, MODE_PDN} pmode_e;

  function automatic int unsigned ps_to_cyc(int unsigned ps, int unsigned clk_ps);
    return (ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rfsh_interval.sv
module rfsh_interval #(
  parameter int unsigned COOL_CYC = 1560,
  parameter int unsigned HOT_CYC  = 780,
  parameter int unsigned OWED_MAX = 8,
  parameter int unsigned IV_W     = 11,
  parameter int unsigned OW_W     = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cnt_en_i,
  input  logic            reload_i,
  input  logic            hot_i,
  input  logic            dec_i,
  input  logic            clr_i,
  output logic [OW_W-1:0] owed_o
);
  logic [IV_W-1:0] iv_q, reload_val;
  logic [OW_W-1:0] owed_q, owed_d;
  logic            expire;

  assign expire     = cnt_en_i && (iv_q == '0);
  assign reload_val = hot_i ? IV_W'(HOT_CYC - 1) : IV_W'(COOL_CYC - 1);

  always_comb begin
    int s;
    s = int'(owed_q) + int'(expire) - int'(dec_i && (owed_q != '0));
    if (s > int'(OWED_MAX)) s = int'(OWED_MAX);
    owed_d = clr_i ? '0 : OW_W'(s);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iv_q   <= IV_W'(COOL_CYC - 1);
      owed_q <= '0;
    end else begin
      if (reload_i || expire) iv_q <= reload_val;
      else if (cnt_en_i)      iv_q <= iv_q - 1'b1;
      owed_q <= owed_d;
    end
  end

  assign owed_o = owed_q;

  // R3
  owed_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owed_q <= OW_W'(OWED_MAX));
  // R3
  owed_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && !dec_i && !clr_i && owed_q < OW_W'(OWED_MAX)) |=> owed_q == $past(owed_q) + 1'b1);
  // R2
  iv_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iv_q <= IV_W'(COOL_CYC - 1));
  // R6
  iv_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_en_i && !reload_i) |=> $stable(iv_q));
endmodule

// File: rtl/recov_timer.sv
module recov_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q, dec;

  assign dec = (cnt_q == '0) ? '0 : cnt_q - 1'b1;

  // a new wait never shortens a pending one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i && val_i > dec)  cnt_q <= val_i;
    else                             cnt_q <= dec;
  end

  assign done_o = (cnt_q == '0);

  // R4
  load_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q >= $past(val_i));
  // R4
  no_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> cnt_q <= $past(cnt_q));
endmodule

// File: rtl/pwr_state.sv
module pwr_state
  import ddr2_tmr_pkg::*;
#(
  parameter int unsigned CKE_CYC = 3
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   sr_enter_i,
  input  logic   sr_exit_i,
  input  logic   pd_enter_i,
  input  logic   pd_exit_i,
  input  logic   pd_active_i,
  output pmode_e mode_o,
  output logic   pd_kind_o,
  output logic   sr_enter_acc_o,
  output logic   sr_exit_acc_o,
  output logic   pd_exit_acc_o
);
  localparam int unsigned DW_W = $clog2(CKE_CYC + 1);

  pmode_e          mode_q, mode_d;
  logic [DW_W-1:0] dwell_q;
  logic            dwell_ok, pd_enter_acc, chg, pd_kind_q;

  assign dwell_ok       = dwell_q >= DW_W'(CKE_CYC - 1);
  assign sr_enter_acc_o = (mode_q == MODE_RUN) && sr_enter_i && dwell_ok;
  assign pd_enter_acc   = (mode_q == MODE_RUN) && !sr_enter_i && pd_enter_i && dwell_ok;
  assign sr_exit_acc_o  = (mode_q == MODE_SREF) && sr_exit_i && dwell_ok;
  assign pd_exit_acc_o  = (mode_q == MODE_PDN) && pd_exit_i && dwell_ok;
  assign chg            = sr_enter_acc_o || pd_enter_acc || sr_exit_acc_o || pd_exit_acc_o;

  always_comb begin
    mode_d = mode_q;
    if (sr_enter_acc_o)                     mode_d = MODE_SREF;
    else if (pd_enter_acc)                  mode_d = MODE_PDN;
    else if (sr_exit_acc_o || pd_exit_acc_o) mode_d = MODE_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MODE_RUN;
      dwell_q   <= DW_W'(CKE_CYC - 1);
      pd_kind_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      if (chg)            dwell_q <= '0;
      else if (!dwell_ok) dwell_q <= dwell_q + 1'b1;
      if (pd_enter_acc)   pd_kind_q <= pd_active_i;
    end
  end

  assign mode_o    = mode_q;
  assign pd_kind_o = pd_kind_q;

  // R9
  cke_dwell_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != $past(mode_q)) |-> $past(dwell_q) >= DW_W'(CKE_CYC - 1));
  // R10
  sref_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SREF && !sr_exit_i) |=> mode_q == MODE_SREF);
endmodule

// File: rtl/ddr2_rfsh_timer.sv
module ddr2_rfsh_timer
  import ddr2_tmr_pkg::*;
#(
  parameter int unsigned CLK_PS      = 5000,
  parameter int unsigned REFI_PS     = 7_800_000,
  parameter int unsigned RFC_PS      = 127_500,
  parameter int unsigned XS_EXTRA_PS = 10_000,
  parameter int unsigned XSRD_CYC    = 200,
  parameter int unsigned XP_CYC      = 2,
  parameter int unsigned XARD_CYC    = 2,
  parameter int unsigned SLOW_BASE   = 8,
  parameter int unsigned CKE_CYC     = 3,
  parameter int unsigned OWED_MAX    = 8,
  parameter int unsigned AL_W        = 3
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             hot_i,
  input  logic                             ref_ack_i,
  input  logic                             sr_enter_i,
  input  logic                             sr_exit_i,
  input  logic                             pd_enter_i,
  input  logic                             pd_exit_i,
  input  logic                             pd_active_i,
  input  logic                             slow_exit_i,
  input  logic [AL_W-1:0]                  al_i,
  output logic                             ref_req_o,
  output logic [$clog2(OWED_MAX+1)-1:0]    ref_owed_o,
  output logic                             ready_nr_o,
  output logic                             ready_rd_o
);
  localparam int unsigned COOL_CYC = ps_to_cyc(REFI_PS, CLK_PS);
  localparam int unsigned HOT_CYC  = ps_to_cyc(REFI_PS / 2, CLK_PS);
  localparam int unsigned RFC_CYC  = ps_to_cyc(RFC_PS, CLK_PS);
  localparam int unsigned XSNR_CYC = ps_to_cyc(RFC_PS + XS_EXTRA_PS, CLK_PS);
  localparam int unsigned REC_MAX  = max2(max2(RFC_CYC, XSNR_CYC),
                                          max2(XSRD_CYC, max2(max2(XP_CYC, XARD_CYC), SLOW_BASE)));
  localparam int unsigned REC_W    = $clog2(REC_MAX + 1);
  localparam int unsigned IV_W     = $clog2(COOL_CYC + 1);
  localparam int unsigned OW_W     = $clog2(OWED_MAX + 1);

  pmode_e           mode;
  logic             pd_kind, sr_enter_acc, sr_exit_acc, pd_exit_acc, ack_eff;
  logic             nr_done, rd_done, run;
  logic [REC_W-1:0] nr_val, rd_val, pd_rd_val;

  pwr_state #(.CKE_CYC(CKE_CYC)) u_state (
    .clk_i, .rst_ni, .sr_enter_i, .sr_exit_i, .pd_enter_i, .pd_exit_i, .pd_active_i,
    .mode_o(mode), .pd_kind_o(pd_kind), .sr_enter_acc_o(sr_enter_acc),
    .sr_exit_acc_o(sr_exit_acc), .pd_exit_acc_o(pd_exit_acc)
  );

  assign run     = (mode == MODE_RUN);
  assign ack_eff = ref_ack_i && run;

  rfsh_interval #(
    .COOL_CYC(COOL_CYC), .HOT_CYC(HOT_CYC), .OWED_MAX(OWED_MAX), .IV_W(IV_W), .OW_W(OW_W)
  ) u_ivl (
    .clk_i, .rst_ni, .cnt_en_i(mode != MODE_SREF), .reload_i(ack_eff || sr_exit_acc),
    .hot_i, .dec_i(ack_eff), .clr_i(sr_enter_acc), .owed_o(ref_owed_o)
  );

  always_comb begin
    if (!pd_kind)                                       pd_rd_val = REC_W'(XP_CYC);
    else if (!slow_exit_i)                              pd_rd_val = REC_W'(XARD_CYC);
    else if (int'(al_i) + int'(XARD_CYC) >= int'(SLOW_BASE)) pd_rd_val = REC_W'(XARD_CYC);
    else                                                pd_rd_val = REC_W'(int'(SLOW_BASE) - int'(al_i));
  end

  assign nr_val = ack_eff ? REC_W'(RFC_CYC) : sr_exit_acc ? REC_W'(XSNR_CYC) : REC_W'(XP_CYC);
  assign rd_val = ack_eff ? REC_W'(RFC_CYC) : sr_exit_acc ? REC_W'(XSRD_CYC) : pd_rd_val;

  recov_timer #(.W(REC_W)) u_nr (
    .clk_i, .rst_ni, .load_i(ack_eff || sr_exit_acc || pd_exit_acc), .val_i(nr_val), .done_o(nr_done)
  );
  recov_timer #(.W(REC_W)) u_rd (
    .clk_i, .rst_ni, .load_i(ack_eff || sr_exit_acc || pd_exit_acc), .val_i(rd_val), .done_o(rd_done)
  );

  assign ref_req_o  = (ref_owed_o != '0);
  assign ready_nr_o = nr_done && run;
  assign ready_rd_o = rd_done && run;

  // R11
  rd_after_nr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_rd_o |-> ready_nr_o);
  // R5
  sr_exit_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_exit_acc |=> !ready_rd_o);
  // R6
  sref_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_SREF) |-> (ref_owed_o == '0));
  // R4
  ack_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_eff |=> !ready_nr_o && !ready_rd_o);
endmodule

// File: tb/sim_ddr2_rfsh_timer.sv
`timescale 1ns/1ps
module sim_ddr2_rfsh_timer;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic hot = 0, ack = 0, sre = 0, srx = 0, pde = 0, pdx = 0, pda = 0, slow = 0;
  logic [2:0] al = '0;
  logic req, rnr, rrd;
  logic [3:0] owed;

  ddr2_rfsh_timer u0 (
    .clk_i(clk), .rst_ni(rst_ni), .hot_i(hot), .ref_ack_i(ack), .sr_enter_i(sre),
    .sr_exit_i(srx), .pd_enter_i(pde), .pd_exit_i(pdx), .pd_active_i(pda),
    .slow_exit_i(slow), .al_i(al), .ref_req_o(req), .ref_owed_o(owed),
    .ready_nr_o(rnr), .ready_rd_o(rrd)
  );

  always #2.5 clk = ~clk;

  int errs = 0, checks = 0;
  string tag = "R1";
  longint cyc = 0;
  int m_mode = 0, m_owed = 0;
  bit m_pdk = 0;
  longint m_last = -100, m_due = 1560, m_nr = 0, m_rd = 0;

  function automatic longint ival(bit h);
    return h ? 780 : 1560;
  endfunction
  function automatic longint lmax(longint a, longint b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s cyc=%0d actual=%0d expected=%0d", tag, what, cyc, act, exp);
    end
  endtask

  // expected behaviour at one clock edge, from the requirements
  task automatic model_edge();
    longint e = cyc;
    bit ok = (e - m_last) >= 3;
    bit ack_eff = ack && (m_mode == 0);
    bit sr_in = 0, sr_out = 0, pd_out = 0, ex;
    int nm = m_mode, o;
    longint w;
    case (m_mode)
      0: if (sre && ok) begin nm = 1; sr_in = 1; end
         else if (pde && ok) begin nm = 2; m_pdk = pda; end
      1: if (srx && ok) begin nm = 0; sr_out = 1; end
      default: if (pdx && ok) begin nm = 0; pd_out = 1; end
    endcase
    if (nm != m_mode) m_last = e;
    if (m_mode != 1) begin
      ex = (e == m_due);
      if (ack_eff || ex) m_due = e + ival(hot);
      o = m_owed + int'(ex) - int'(ack_eff && m_owed > 0);
      if (o > 8) o = 8;
      m_owed = o;
    end
    if (sr_in) m_owed = 0;
    if (sr_out) m_due = e + ival(hot);
    if (ack_eff) begin m_nr = lmax(m_nr, e + 26); m_rd = lmax(m_rd, e + 26); end
    if (sr_out) begin m_nr = lmax(m_nr, e + 28); m_rd = lmax(m_rd, e + 200); end
    if (pd_out) begin
      w = 2;
      if (m_pdk && slow) w = lmax(8 - longint'(al), 2);
      m_nr = lmax(m_nr, e + 2);
      m_rd = lmax(m_rd, e + w);
    end
    m_mode = nm;
  endtask

  task automatic compare();
    chk("ref_req_o", longint'(req), longint'(m_owed > 0));
    chk("ref_owed_o", longint'(owed), longint'(m_owed));
    chk("ready_nr_o", longint'(rnr), longint'(m_mode == 0 && cyc >= m_nr));
    chk("ready_rd_o", longint'(rrd), longint'(m_mode == 0 && cyc >= m_rd));
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      cyc++;
      model_edge();
      @(negedge clk);
      compare();
    end
  endtask

  task automatic clear_strobes();
    ack = 0; sre = 0; srx = 0; pde = 0; pdx = 0;
  endtask

  // 0 ack, 1 sr enter, 2 sr exit, 3 pd enter, 4 pd exit
  task automatic strobe(input int which);
    case (which)
      0: ack = 1;
      1: sre = 1;
      2: srx = 1;
      3: pde = 1;
      default: pdx = 1;
    endcase
    step(1);
    clear_strobes();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errs++; checks++;
    $display("FAIL watchdog expired at cyc=%0d", cyc);
    finish_run();
  end

  initial begin
    int unsigned r;
    r = $urandom(32'h1d2e);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    tag = "R1";
    compare();
    chk("R1 req", longint'(req), 0);
    chk("R1 rd", longint'(rrd), 1);

    tag = "R2"; step(1559);
    chk("R2 no req before interval", longint'(req), 0);
    step(1);
    chk("R2 req at interval", longint'(req), 1);
    hot = 1;
    tag = "R4"; strobe(0); step(30);
    tag = "R2"; step(800);

    tag = "R3"; step(780 * 10);
    chk("R3 saturated", longint'(owed), 8);
    for (int k = 0; k < 9; k++) begin strobe(0); step(29); end

    tag = "R6"; strobe(1);
    tag = "R9"; strobe(2); strobe(2);
    tag = "R5"; strobe(2); step(205);

    tag = "R7"; pda = 0; strobe(3); step(2); strobe(4); step(4);
    tag = "R8"; pda = 1; strobe(3); step(2); slow = 0; strobe(4); step(4);
    for (int k = 0; k < 4; k++) begin
      al = 3'(k * 2 + 1); slow = 1;
      strobe(3); step(2); strobe(4); step(10);
    end
    tag = "R9"; strobe(3); strobe(4); strobe(4); strobe(4); step(4);
    tag = "R10"; hot = 0; strobe(3); step(2); strobe(0);
    chk("R10 ready low in power-down", longint'(rnr), 0);
    step(2000); strobe(4); step(30);

    tag = "R11";
    for (int k = 0; k < 30000; k++) begin
      r = $urandom % 1000;
      if (r < 8 || (r == 8 && !req)) ack = req || r == 8;
      else if (r < 11) sre = 1;
      else if (r < 40) srx = 1;
      else if (r < 43) pde = 1;
      else if (r < 80) pdx = 1;
      if (r >= 995) hot = ~hot;
      al = 3'($urandom % 8);
      slow = 1'($urandom % 2);
      pda = 1'($urandom % 2);
      step(1);
      clear_strobes();
    end
    finish_run();
  end
endmodule